// File: doc/BRIEF.md
# Time-of-Day Counter with Drift Correction

This block keeps a running time of day in a pair of 32-bit words, advancing by a fixed nominal step (64 ns at a 15.625 MHz counter clock) on every enabled clock. The pair is read either as seconds and nanoseconds, with a programmable nanosecond rollover, or as one 64-bit nanosecond count. Software sets the start time while the counter is stopped. It can add a signed offset at any time. It can also arm a preload that lands on the next rising edge of an external pulse, which aligns the time to a once-per-second reference.

Small frequency errors are trimmed by a drift engine. When started, it changes the step on every subperiod-th running clock, for a programmed number of periods. A swallow drops that step to zero. A jump replaces it with a programmed increment. All access goes through a plain register port: a write strobe with address and data, and a read strobe whose data appears one clock later. The port has no back-pressure: every write and every read is accepted in the cycle it is presented.

Top module: `tod_counter`

## Requirements
- R1: After reset both count words are zero, the control register reads 0, the rollover register reads 999,999,999 and the drift command register reads 0.
- R2: While control bit 0 is set the count advances by 64 ns on every clock; while it is clear the count holds.
- R3: With control bit 1 clear (seconds/nanoseconds format), a nanosecond value that would exceed the rollover register wraps by subtracting rollover+1 and carries one into the seconds word (the rollover must be at least the step).
- R4: With control bit 1 set (nanosecond format), the high and low words form one 64-bit count, and the low word carries into the high word.
- R5: Writes to the value-low (0x04) and value-high (0x08) registers set the count while control bit 0 is clear and are ignored while it is set.
- R6: Writing offset-high (0x14) applies an offset together with the stored offset-low (0x10). In seconds/nanoseconds format the low word is nanoseconds (at most the rollover) and the high word is signed seconds. In nanosecond format {high, low} is a signed 64-bit addend.
- R7: A control write with bit 2 set arms a preload, and control bit 14 then reads 1. On the next rising edge of the pulse input the count is loaded from preload-low (0x18) and preload-high (0x1C) and bit 14 clears. A pulse with nothing armed has no effect.
- R8: Drift register 0x20 holds the direction in bit 31, the subperiod in bits 3:0 (0 acts as 1) and the period in bits 28:12. With bit 31 clear (swallow), every subperiod-th running clock after a start advances the count by 0 instead of 64, for period such clocks.
- R9: With bit 31 set (jump), those same clocks advance the count by the increment register (0x24) instead of 64.
- R10: Writing bit 0 of command register 0x28 starts a correction. Bit 1 reads 1 while it runs. A start while busy, or with period 0, is ignored, and the configuration is captured at the start.
- R11: A read of live-low (0x30) returns the low word and captures the high word, and a later read of live-high (0x34) returns that captured word. All read data appears on the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rdata | output | 32 | Read data, valid the clock after rd_en |
| pps_in | input | 1 | External alignment pulse for the armed preload |

## Verification
On every cycle the checker confirms several things. A stopped counter with no write and no preload holds its value. In nanosecond format, a running counter outside any correction steps by exactly 64. In the other format the nanosecond word never passes the rollover. A fired preload clears its pending flag, and busy only rises after an accepted start. The bench scenarios show the behaviour that only exact values reveal: the wrap-and-carry arithmetic, signed offsets in both formats, the exact count lost or gained by swallow and jump, that writes and restarts are ignored at the right times, and the coherent two-word read.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam logic [5:0] A_CTRL    = 6'h00;
  localparam logic [5:0] A_VAL_LO  = 6'h04;
  localparam logic [5:0] A_VAL_HI  = 6'h08;
  localparam logic [5:0] A_ROLL    = 6'h0C;
  localparam logic [5:0] A_OFF_LO  = 6'h10;
  localparam logic [5:0] A_OFF_HI  = 6'h14;
  localparam logic [5:0] A_PRE_LO  = 6'h18;
  localparam logic [5:0] A_PRE_HI  = 6'h1C;
  localparam logic [5:0] A_DUR     = 6'h20;
  localparam logic [5:0] A_INC     = 6'h24;
  localparam logic [5:0] A_CMD     = 6'h28;
  localparam logic [5:0] A_LIVE_LO = 6'h30;
  localparam logic [5:0] A_LIVE_HI = 6'h34;

  localparam int PER_LSB = 12;
  localparam int PER_W   = 17;
  localparam int SUB_W   = 4;

  typedef struct packed {
    logic             dir;
    logic [PER_W-1:0] period;
    logic [SUB_W-1:0] sub;
  } drift_cfg_t;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 6,
  parameter int ROLL_RST = 999_999_999
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] cnt_hi,
  input  logic [DW-1:0] cnt_lo,
  input  logic          busy,
  input  logic          pend,
  output logic          run,
  output logic          fmt_ns,
  output logic          ctrl_wr,
  output logic          arm_bit,
  output logic [DW-1:0] roll,
  output logic [DW-1:0] off_lo,
  output logic          off_apply,
  output logic [DW-1:0] pre_lo,
  output logic [DW-1:0] pre_hi,
  output logic          val_lo_wr,
  output logic          val_hi_wr,
  output drift_cfg_t    dcfg,
  output logic [DW-1:0] inc,
  output logic          drift_start
);
  logic          arm_q;
  logic [DW-1:0] snap_hi;

  assign ctrl_wr     = wr_en && (addr == A_CTRL);
  assign arm_bit     = wdata[2];
  assign off_apply   = wr_en && (addr == A_OFF_HI);
  assign val_lo_wr   = wr_en && (addr == A_VAL_LO);
  assign val_hi_wr   = wr_en && (addr == A_VAL_HI);
  assign drift_start = wr_en && (addr == A_CMD) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      fmt_ns <= 1'b0;
      arm_q  <= 1'b0;
      roll   <= DW'(ROLL_RST);
      off_lo <= '0;
      pre_lo <= '0;
      pre_hi <= '0;
      dcfg   <= '0;
      inc    <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          run    <= wdata[0];
          fmt_ns <= wdata[1];
          arm_q  <= wdata[2];
        end
        A_ROLL:   roll   <= wdata;
        A_OFF_LO: off_lo <= wdata;
        A_PRE_LO: pre_lo <= wdata;
        A_PRE_HI: pre_hi <= wdata;
        A_DUR: begin
          dcfg.dir    <= wdata[DW-1];
          dcfg.period <= wdata[PER_LSB +: PER_W];
          dcfg.sub    <= wdata[SUB_W-1:0];
        end
        A_INC:    inc    <= wdata;
        default: ;
      endcase
    end
  end

  // Registered read port with a high-word snapshot for coherent 64-bit reads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata   <= '0;
      snap_hi <= '0;
    end else if (rd_en) begin
      case (addr)
        A_CTRL:    rdata <= {17'b0, pend, 11'b0, arm_q, fmt_ns, run};
        A_VAL_LO:  rdata <= cnt_lo;
        A_VAL_HI:  rdata <= cnt_hi;
        A_ROLL:    rdata <= roll;
        A_OFF_LO:  rdata <= off_lo;
        A_PRE_LO:  rdata <= pre_lo;
        A_PRE_HI:  rdata <= pre_hi;
        A_DUR:     rdata <= {dcfg.dir, 2'b0, dcfg.period, 8'b0, dcfg.sub};
        A_INC:     rdata <= inc;
        A_CMD:     rdata <= {30'b0, busy, 1'b0};
        A_LIVE_LO: begin
          rdata   <= cnt_lo;
          snap_hi <= cnt_hi;
        end
        A_LIVE_HI: rdata <= snap_hi;
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tod_preload.sv
module tod_preload #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_in,
  input  logic ctrl_wr,
  input  logic arm_bit,
  output logic pend,
  output logic fire
);
  logic [SYNC:0] chain;
  logic          pulse_q;

  assign chain[0] = pps_in;

  generate
    for (genvar i = 1; i <= SYNC; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign fire = pend && chain[SYNC] && !pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      pend    <= 1'b0;
    end else begin
      pulse_q <= chain[SYNC];
      if (ctrl_wr)   pend <= arm_bit;
      else if (fire) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/tod_drift.sv
module tod_drift
  import tod_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NOM = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start,
  input  drift_cfg_t    cfg,
  input  logic [DW-1:0] inc,
  output logic          busy,
  output logic [DW-1:0] step
);
  logic             dir_q;
  logic [SUB_W-1:0] sub_q;
  logic [SUB_W-1:0] sub_cnt;
  logic [PER_W-1:0] left_q;
  logic [DW-1:0]    inc_q;
  logic [SUB_W-1:0] sub_last;
  logic             corr;

  assign sub_last = (sub_q == '0) ? '0 : sub_q - 1'b1;
  assign corr     = busy && run && (sub_cnt == sub_last);
  assign step     = corr ? (dir_q ? inc_q : '0) : DW'(NOM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      dir_q   <= 1'b0;
      sub_q   <= '0;
      sub_cnt <= '0;
      left_q  <= '0;
      inc_q   <= '0;
    end else if (!busy) begin
      if (start && cfg.period != '0) begin
        busy    <= 1'b1;
        dir_q   <= cfg.dir;
        sub_q   <= cfg.sub;
        left_q  <= cfg.period;
        inc_q   <= inc;
        sub_cnt <= '0;
      end
    end else if (run) begin
      if (corr) begin
        sub_cnt <= '0;
        left_q  <= left_q - 1'b1;
        if (left_q == PER_W'(1)) busy <= 1'b0;
      end else begin
        sub_cnt <= sub_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          fmt_ns,
  input  logic [DW-1:0] step,
  input  logic [DW-1:0] roll,
  input  logic          val_lo_wr,
  input  logic          val_hi_wr,
  input  logic [DW-1:0] wdata,
  input  logic          off_apply,
  input  logic [DW-1:0] off_lo,
  input  logic          fire,
  input  logic [DW-1:0] pre_lo,
  input  logic [DW-1:0] pre_hi,
  output logic [DW-1:0] cnt_hi,
  output logic [DW-1:0] cnt_lo
);
  localparam int XW = DW + 2;

  logic [DW-1:0]   step_eff;
  logic [XW-1:0]   lim, a, a1, b, b1;
  logic            c1, c2;
  logic [DW-1:0]   sec_n;
  logic [2*DW-1:0] wide_n;
  logic [DW-1:0]   nx_hi, nx_lo;

  always_comb begin
    step_eff = run ? step : '0;
    // seconds/nanoseconds arithmetic: step, then offset, each normalised
    lim   = {2'b0, roll} + XW'(1);
    a     = {2'b0, cnt_lo} + {2'b0, step_eff};
    c1    = (a >= lim);
    a1    = c1 ? a - lim : a;
    b     = a1 + (off_apply ? {2'b0, off_lo} : '0);
    c2    = (b >= lim);
    b1    = c2 ? b - lim : b;
    sec_n = cnt_hi + (off_apply ? wdata : '0)
          + {{(DW-1){1'b0}}, c1} + {{(DW-1){1'b0}}, c2};
    // nanosecond-only arithmetic over the full pair
    wide_n = {cnt_hi, cnt_lo} + {{DW{1'b0}}, step_eff}
           + (off_apply ? {wdata, off_lo} : '0);

    if (fmt_ns) begin
      nx_hi = wide_n[2*DW-1:DW];
      nx_lo = wide_n[DW-1:0];
    end else begin
      nx_hi = sec_n;
      nx_lo = b1[DW-1:0];
    end

    if (fire) begin
      nx_hi = pre_hi;
      nx_lo = pre_lo;
    end else if (!run && val_hi_wr) begin
      nx_hi = wdata;
      nx_lo = cnt_lo;
    end else if (!run && val_lo_wr) begin
      nx_hi = cnt_hi;
      nx_lo = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_hi <= '0;
      cnt_lo <= '0;
    end else begin
      cnt_hi <= nx_hi;
      cnt_lo <= nx_lo;
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 6,
  parameter int NOM_STEP = 64,
  parameter int ROLL_RST = 999_999_999,
  parameter int SYNC     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  input  logic          pps_in
);
  logic          run, fmt_ns, ctrl_wr, arm_bit, off_apply;
  logic          val_lo_wr, val_hi_wr, drift_start, busy, pend, fire;
  logic [DW-1:0] roll, off_lo, pre_lo, pre_hi, inc, step, cnt_hi, cnt_lo;
  drift_cfg_t    dcfg;

  tod_regs #(.DW(DW), .AW(AW), .ROLL_RST(ROLL_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
    .busy(busy), .pend(pend), .run(run), .fmt_ns(fmt_ns),
    .ctrl_wr(ctrl_wr), .arm_bit(arm_bit), .roll(roll), .off_lo(off_lo),
    .off_apply(off_apply), .pre_lo(pre_lo), .pre_hi(pre_hi),
    .val_lo_wr(val_lo_wr), .val_hi_wr(val_hi_wr), .dcfg(dcfg), .inc(inc),
    .drift_start(drift_start)
  );

  tod_preload #(.SYNC(SYNC)) u_pre (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .ctrl_wr(ctrl_wr),
    .arm_bit(arm_bit), .pend(pend), .fire(fire)
  );

  tod_drift #(.DW(DW), .NOM(NOM_STEP)) u_drift (
    .clk(clk), .rst_n(rst_n), .run(run), .start(drift_start), .cfg(dcfg),
    .inc(inc), .busy(busy), .step(step)
  );

  tod_accum #(.DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .run(run), .fmt_ns(fmt_ns), .step(step),
    .roll(roll), .val_lo_wr(val_lo_wr), .val_hi_wr(val_hi_wr),
    .wdata(wdata), .off_apply(off_apply), .off_lo(off_lo), .fire(fire),
    .pre_lo(pre_lo), .pre_hi(pre_hi), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo)
  );
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int DW  = 32,
  parameter int NOM = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          fmt_ns,
  input logic          busy,
  input logic          wr_en,
  input logic          drift_start,
  input logic          fire,
  input logic          pend,
  input logic [DW-1:0] roll,
  input logic [DW-1:0] cnt_hi,
  input logic [DW-1:0] cnt_lo
);
  // R2: stopped counter with no write and no preload holds
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en && !fire) |=> $stable({cnt_hi, cnt_lo}));

  // R4: nanosecond format advances by the nominal step outside corrections
  a_r4_nominal_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_ns && run && !busy && !wr_en && !fire)
    |=> {cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + (2*DW)'(NOM));

  // R3: nanosecond word stays within the rollover once inside it
  a_r3_within_roll: assert property (@(posedge clk) disable iff (!rst_n)
    (!fmt_ns && run && !busy && !wr_en && !fire && cnt_lo <= roll)
    |=> cnt_lo <= roll);

  // R7: a fired preload clears the pending flag
  a_r7_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_en) |=> !pend);

  // R10: busy only rises after a start command
  a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(drift_start));
endmodule

bind tod_counter tod_counter_chk #(.DW(DW), .NOM(NOM_STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .fmt_ns(fmt_ns), .busy(busy),
  .wr_en(wr_en), .drift_start(drift_start), .fire(fire), .pend(pend),
  .roll(roll), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo)
);

// File: tb/tod_counter_test.sv
module tod_counter_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rd_en = 0;
  logic [31:0] rdata;
  logic        pps_in = 0;
  int checks = 0;
  int fails  = 0;
  logic [31:0] v;

  tod_counter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .pps_in(pps_in)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    rd_en = 1; addr = a;
    @(posedge clk); #1;
    rd_en = 0;
    d = rdata;
  endtask

  task automatic run_for(int k);
    wr(6'h00, 32'h1);
    idle(k - 1);
    wr(6'h00, 32'h0);
  endtask

  task automatic t_reset;
    rd(6'h00, v); check("R1 ctrl", v, 0);
    rd(6'h0C, v); check("R1 roll", v, 32'd999_999_999);
    rd(6'h30, v); check("R1 lo", v, 0);
    rd(6'h34, v); check("R1 hi", v, 0);
    rd(6'h28, v); check("R1 cmd", v, 0);
  endtask

  task automatic t_rollover;
    wr(6'h0C, 999);
    wr(6'h04, 960); wr(6'h08, 5);
    wr(6'h00, 1); wr(6'h00, 0);
    rd(6'h30, v); check("R3 wrap lo", v, 24);
    rd(6'h34, v); check("R3 carry hi", v, 6);
    idle(5);
    rd(6'h30, v); check("R2 hold", v, 24);
    run_for(3);
    rd(6'h30, v); check("R2 step", v, 24 + 192);
  endtask

  task automatic t_nsmode;
    wr(6'h00, 2);
    wr(6'h04, 32'hFFFF_FFC0); wr(6'h08, 1);
    wr(6'h00, 3); wr(6'h00, 2);
    rd(6'h30, v); check("R4 lo", v, 0);
    rd(6'h34, v); check("R4 hi", v, 2);
  endtask

  task automatic t_value_ignore;
    wr(6'h00, 0); wr(6'h0C, 999);
    wr(6'h04, 0); wr(6'h08, 3);
    wr(6'h00, 1);
    wr(6'h08, 50); wr(6'h04, 7);
    wr(6'h00, 0);
    rd(6'h30, v); check("R5 lo ignored", v, 192);
    rd(6'h34, v); check("R5 hi ignored", v, 3);
  endtask

  task automatic t_offset;
    wr(6'h04, 900); wr(6'h08, 10);
    wr(6'h10, 200); wr(6'h14, 32'hFFFF_FFFD);
    rd(6'h30, v); check("R6 sec lo", v, 100);
    rd(6'h34, v); check("R6 sec hi", v, 8);
    wr(6'h00, 2);
    wr(6'h04, 32'hFFFF_FF00); wr(6'h08, 4);
    wr(6'h10, 32'h200); wr(6'h14, 0);
    rd(6'h30, v); check("R6 ns lo", v, 32'h100);
    rd(6'h34, v); check("R6 ns hi", v, 5);
    wr(6'h10, 32'hFFFF_FE00); wr(6'h14, 32'hFFFF_FFFF);
    rd(6'h30, v); check("R6 neg lo", v, 32'hFFFF_FF00);
    rd(6'h34, v); check("R6 neg hi", v, 4);
  endtask

  task automatic pulse;
    pps_in = 1; idle(4); pps_in = 0; idle(4);
  endtask

  task automatic t_preload;
    wr(6'h00, 0);
    wr(6'h04, 0); wr(6'h08, 0);
    wr(6'h18, 123); wr(6'h1C, 77);
    pulse();
    rd(6'h34, v); // snapshot via lo first
    rd(6'h30, v); rd(6'h34, v); check("R7 unarmed", v, 0);
    wr(6'h00, 4);
    rd(6'h00, v); check("R7 pending", v, 32'h4004);
    pulse();
    rd(6'h30, v); check("R7 lo", v, 123);
    rd(6'h34, v); check("R7 hi", v, 77);
    rd(6'h00, v); check("R7 cleared", v, 32'h0004);
    wr(6'h00, 0);
  endtask

  task automatic t_swallow;
    wr(6'h0C, 999_999); wr(6'h04, 0); wr(6'h08, 0);
    wr(6'h20, (3 << 12) | 4); wr(6'h24, 0);
    wr(6'h28, 1);
    rd(6'h28, v); check("R10 busy", v, 2);
    run_for(20);
    rd(6'h30, v); check("R8 swallow", v, 17 * 64);
    rd(6'h28, v); check("R10 done", v, 0);
  endtask

  task automatic t_jump;
    wr(6'h04, 0);
    wr(6'h20, 32'h8000_0000 | (2 << 12) | 4); wr(6'h24, 128);
    wr(6'h28, 1);
    run_for(10);
    rd(6'h30, v); check("R9 jump", v, 8 * 64 + 2 * 128);
  endtask

  task automatic t_busy;
    wr(6'h04, 0);
    wr(6'h20, (2 << 12) | 4); wr(6'h28, 1);
    wr(6'h20, (5 << 12) | 4); wr(6'h28, 1);
    run_for(12);
    rd(6'h30, v); check("R10 restart ignored", v, 10 * 64);
    wr(6'h20, 4); wr(6'h28, 1);
    rd(6'h28, v); check("R10 zero period", v, 0);
  endtask

  task automatic t_coherent;
    wr(6'h00, 2);
    wr(6'h04, 5); wr(6'h08, 1);
    rd(6'h30, v); check("R11 lo", v, 5);
    wr(6'h08, 9);
    rd(6'h34, v); check("R11 snapshot", v, 1);
    rd(6'h30, v);
    rd(6'h34, v); check("R11 refresh", v, 9);
  endtask

  initial begin
    #100_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_rollover();
    t_nsmode();
    t_value_ignore();
    t_offset();
    t_preload();
    t_swallow();
    t_jump();
    t_busy();
    t_coherent();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule